// File: doc/BRIEF.md
# Page Write Load Controller

This block is the write side of a byte-wide nonvolatile memory model. It samples the chip-enable, write-enable and output-enable strobes of an asynchronous host bus on the system clock. It accepts a write only while chip-enable and write-enable are both low and output-enable is high. The address is taken when that combined strobe opens and the data when it closes. Accepted bytes collect in a page buffer. Every byte in the buffer shares one locked page number, which is the address bits above the byte offset.

The page stays open for as long as each new write starts within a load window counted from the start of the previous accepted write. Once the window passes with no new write, a self-timed programming phase starts. It is a counter of `T_PROG` cycles, followed by a sweep that copies every loaded byte into the storage array. The busy output is high for the whole phase, and write strobes that begin during it are dropped. A registered read port exposes the storage array, so the result of each page can be observed.

Top module: `pwl_page_load_ctrl`

## Requirements
- R1: A write is recognised only while `ce_n`=0, `we_n`=0 and `oe_n`=1 hold together. A strobe with `oe_n`=0, or with `we_n` low while `ce_n` is high, changes no stored byte and starts no programming.
- R2: The address of a write is the one present when the combined strobe opens. The data is the last value sampled before the strobe closes. Address and data may both change while the strobe is low.
- R3: A page holds 2^`PAGE_W` bytes. `addr[ADDR_W-1:PAGE_W]` selects the page and `addr[PAGE_W-1:0]` selects the byte. After programming, each loaded byte reads back at its own address, and bytes of that page that were not loaded keep their previous values.
- R4: A write that starts no more than `T_LOAD`-4 cycles after the start of the previous accepted write joins the same page. Busy rises between `T_LOAD` and `T_LOAD`+10 cycles after the last accepted write began on the pins.
- R5: While a page is open, a write whose page bits differ from the locked page is ignored. It does not restart the load window.
- R6: A combined strobe held for fewer than `MIN_LOW` sampled cycles is ignored. A strobe of exactly `MIN_LOW` cycles is accepted.
- R7: Busy stays high for exactly `T_PROG` + 2^`PAGE_W` cycles per programming phase, and storage is written only while busy is high.
- R8: Write strobes that begin while busy is high are ignored. They neither change stored data nor open a new page.
- R9: Any stored byte can be overwritten by any value with no erase step; 0x00 can follow 0xFF and 0xFF can follow 0x00.
- R10: After reset, busy is low, and programming never starts without an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address from the host |
| din | input | DATA_W | Write data from the host |
| rd_addr | input | ADDR_W | Read address into the storage array |
| rd_data | output | DATA_W | Registered storage read data, valid one cycle after `rd_addr` |
| busy | output | 1 | High while programming and commit run |

## Verification
The bench fills every page of a small configuration and predicts each byte from a formula. A design that committed the wrong offset or lost part of a page shows mismatches in the full read-back. Directed cases target the strobe edges. An address moved mid-strobe catches a design that captures the address late. Two- and three-cycle pulses catch an off-by-one in the glitch filter. Writes to a foreign page must leave the window anchored to the first write, or busy rises late. Writes issued during busy must leave old data intact and must not trigger a second programming phase.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [1:0] {
    PS_IDLE,
    PS_LOAD,
    PS_PROG,
    PS_COMMIT
  } pwl_state_e;
endpackage

// File: rtl/pwl_sync.sv
module pwl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= rst_val;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwl_load_detect.sv
module pwl_load_detect #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 8,
  parameter int MIN_LOW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              block,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  output logic              ld_valid,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic [LEN_W-1:0]  ld_len
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LOW);

  logic act_d;
  logic blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_d    <= 1'b0;
      blk      <= 1'b0;
      ld_valid <= 1'b0;
      ld_addr  <= '0;
      ld_data  <= '0;
      ld_len   <= '0;
    end else begin
      act_d    <= act;
      ld_valid <= 1'b0;
      if (act && !act_d) begin
        // strobe opens: address is fixed here
        ld_addr <= addr_s;
        ld_data <= din_s;
        ld_len  <= LEN_W'(1);
        blk     <= block;
      end else if (act) begin
        ld_data <= din_s;
        if (ld_len != '1) ld_len <= ld_len + 1'b1;
      end
      if (!act && act_d) ld_valid <= !blk && (ld_len >= MIN_L);
    end
  end
endmodule

// File: rtl/pwl_page_buf.sv
module pwl_page_buf #(
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PAGE_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  input  logic [PAGE_W-1:0] ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [DATA_W-1:0] entry [DEPTH];
  logic [DEPTH-1:0]  vld;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [DATA_W-1:0] b_q;
    logic              v_q;
    logic              hit;
    assign hit = we && (widx == PAGE_W'(i));
    always_ff @(posedge clk) begin
      if (rst || clr) v_q <= 1'b0;
      else if (hit)   v_q <= 1'b1;
      if (hit) b_q <= wdata;
    end
    assign entry[i] = b_q;
    assign vld[i]   = v_q;
  end

  assign rdata  = entry[ridx];
  assign rvalid = vld[ridx];
endmodule

// File: rtl/pwl_store.sv
module pwl_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pwl_page_load_ctrl.sv
module pwl_page_load_ctrl #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 8,
  parameter int T_LOAD      = 5000,
  parameter int T_PROG      = 250000,
  parameter int MIN_LOW     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  import pwl_pkg::*;

  localparam int PAGE  = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int SW    = 3 + ADDR_W + DATA_W;
  localparam int LEN_W = $clog2(T_LOAD + 1) + 1;
  localparam int PC_W  = $clog2(T_PROG + 1);
  localparam logic [LEN_W-1:0] TL   = LEN_W'(T_LOAD);
  localparam logic [PC_W-1:0]  PEND = PC_W'(T_PROG - 1);

  // bus synchronisation: strobes, address and data share one pipeline
  logic [SW-1:0] bus_s;
  logic          ce_s, we_s, oe_s, act, act_q;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;

  pwl_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d       ({ce_n, we_n, oe_n, addr, din}),
    .rst_val ({3'b111, {(SW-3){1'b0}}}),
    .q       (bus_s)
  );

  assign ce_s   = bus_s[SW-1];
  assign we_s   = bus_s[SW-2];
  assign oe_s   = bus_s[SW-3];
  assign addr_s = bus_s[DATA_W +: ADDR_W];
  assign din_s  = bus_s[DATA_W-1:0];
  assign act    = !ce_s && !we_s && oe_s;

  // byte load detection
  logic              ld_valid;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data;
  logic [LEN_W-1:0]  ld_len;
  logic [PG_W-1:0]   ld_page;

  pwl_load_detect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LOW(MIN_LOW)) u_det (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .block    (busy),
    .addr_s   (addr_s),
    .din_s    (din_s),
    .ld_valid (ld_valid),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .ld_len   (ld_len)
  );

  assign ld_page = ld_addr[ADDR_W-1:PAGE_W];

  // control state
  pwl_state_e        state;
  logic [LEN_W-1:0]  timer;
  logic [PC_W-1:0]   pcnt;
  logic [PAGE_W-1:0] cidx;
  logic [PG_W-1:0]   lock_page;
  logic              in_load, page_hit, buf_we, start_prog, mem_we;
  logic [DATA_W-1:0] pb_data;
  logic              pb_valid;

  assign in_load    = (state == PS_LOAD);
  assign page_hit   = (ld_page == lock_page);
  assign buf_we     = ld_valid && ((state == PS_IDLE) || (in_load && page_hit));
  assign start_prog = !act && !act_q && !ld_valid && (timer >= TL);
  assign mem_we     = (state == PS_COMMIT) && pb_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_IDLE;
      busy      <= 1'b0;
      act_q     <= 1'b0;
      timer     <= '0;
      pcnt      <= '0;
      cidx      <= '0;
      lock_page <= '0;
    end else begin
      act_q <= act;
      case (state)
        PS_IDLE: begin
          if (ld_valid) begin
            lock_page <= ld_page;
            timer     <= ld_len;
            state     <= PS_LOAD;
          end
        end
        PS_LOAD: begin
          if (ld_valid && page_hit) begin
            timer <= ld_len;
          end else if (start_prog) begin
            state <= PS_PROG;
            busy  <= 1'b1;
            pcnt  <= '0;
          end else if (timer != '1) begin
            timer <= timer + 1'b1;
          end
        end
        PS_PROG: begin
          if (pcnt == PEND) begin
            state <= PS_COMMIT;
            cidx  <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        PS_COMMIT: begin
          if (cidx == '1) begin
            state <= PS_IDLE;
            busy  <= 1'b0;
          end else begin
            cidx <= cidx + 1'b1;
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  pwl_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_pbuf (
    .clk    (clk),
    .rst    (rst),
    .we     (buf_we),
    .widx   (ld_addr[PAGE_W-1:0]),
    .wdata  (ld_data),
    .clr    ((state == PS_COMMIT) && (cidx == '1)),
    .ridx   (cidx),
    .rdata  (pb_data),
    .rvalid (pb_valid)
  );

  pwl_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr ({lock_page, cidx}),
    .wdata (pb_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/pwl_page_load_chk.sv
module pwl_page_load_chk #(
  parameter int T_PROG  = 40,
  parameter int PAGE    = 16,
  parameter int MIN_LOW = 2,
  parameter int LEN_W   = 8,
  parameter int PG_W    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             act,
  input logic             buf_we,
  input logic             mem_we,
  input logic             in_load,
  input logic [LEN_W-1:0] ld_len,
  input logic [PG_W-1:0]  ld_page,
  input logic [PG_W-1:0]  lock_page
);
  int bcnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) bcnt <= 0;
    else              bcnt <= bcnt + 1;
  end

  // R6: only strobes of at least MIN_LOW cycles reach the page buffer
  a_r6_min_length: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> ld_len >= LEN_W'(MIN_LOW));

  // R8: nothing is loaded while programming
  a_r8_no_load_busy: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> !busy);

  // R5: loads into an open page carry the locked page number
  a_r5_page_locked: assert property (@(posedge clk) disable iff (rst)
    (buf_we && in_load) |-> ld_page == lock_page);

  // R7: storage written only inside the busy phase
  a_r7_write_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R7: busy length
  a_r7_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> bcnt == T_PROG + PAGE);

  // R4: programming never starts while a strobe is active
  a_r4_no_start_mid_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(act));

  // R10: reset leaves the block idle
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> !busy);
endmodule

bind pwl_page_load_ctrl pwl_page_load_chk #(
  .T_PROG  (T_PROG),
  .PAGE    (PAGE),
  .MIN_LOW (MIN_LOW),
  .LEN_W   (LEN_W),
  .PG_W    (PG_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .act       (act),
  .buf_we    (buf_we),
  .mem_we    (mem_we),
  .in_load   (in_load),
  .ld_len    (ld_len),
  .ld_page   (ld_page),
  .lock_page (lock_page)
);

// File: tb/pwl_page_load_ctrl_test.sv
module pwl_page_load_ctrl_test;
  localparam int ADDR_W  = 7;
  localparam int PAGE_W  = 4;
  localparam int PAGE    = 1 << PAGE_W;
  localparam int NPAGE   = 1 << (ADDR_W - PAGE_W);
  localparam int T_LOAD  = 20;
  localparam int T_PROG  = 40;
  localparam int MIN_LOW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0, rd_addr = '0;
  logic [7:0] din = '0;
  logic [7:0] rd_data;
  logic busy;

  always #10 clk = ~clk;

  pwl_page_load_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(8), .PAGE_W(PAGE_W), .T_LOAD(T_LOAD),
    .T_PROG(T_PROG), .MIN_LOW(MIN_LOW), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  int checks = 0, errors = 0;
  int cyc = 0, rise_n = 0, fall_n = 0, rise_cyc = 0, last_len = 0;
  bit busy_prev = 1'b0, done = 1'b0;
  logic [7:0] exp_mem [1 << ADDR_W];

  always @(negedge clk) begin
    cyc++;
    if (busy && !busy_prev) begin rise_n++; rise_cyc = cyc; end
    if (!busy && busy_prev) begin fall_n++; last_len = cyc - rise_cyc; end
    busy_prev = busy;
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic check_rng(input string tag, input int actual, input int lo, input int hi);
    checks++;
    if (actual < lo || actual > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, actual, lo, hi);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // generic strobe: we_n low for lo cycles, ce_n low one cycle longer
  task automatic strobe(input int a, input int d, input int lo, input bit oe_low, input bit ce_high);
    @(negedge clk);
    addr = ADDR_W'(a); din = 8'(d);
    ce_n = ce_high; oe_n = !oe_low; we_n = 1'b0;
    repeat (lo) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input int a, input int d);
    strobe(a, d, 4, 1'b0, 1'b0);
  endtask

  // address and data move while the strobe is low
  task automatic wr_shift(input int a0, input int a1, input int d0, input int d1);
    @(negedge clk);
    addr = ADDR_W'(a0); din = 8'(d0); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk);
    addr = ADDR_W'(a1); din = 8'(d1);
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic wait_prog(input int f0, input string tag);
    int g = 0;
    while (fall_n == f0 && g < 1000) begin @(negedge clk); g++; end
    check({tag, " programming completes"}, int'(fall_n > f0), 1);
    idle(2);
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic check_page(input int p, input string tag);
    int v;
    for (int i = 0; i < PAGE; i++) begin
      rd(p * PAGE + i, v);
      check(tag, v, int'(exp_mem[p * PAGE + i]));
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0, r0, c0, v;
    idle(5);
    rst = 1'b0;
    @(negedge clk);
    check("R10 busy low after reset", int'(busy), 0);
    idle(30);
    check("R10 no programming without a load", rise_n, 0);

    // R3/R7/R4: fill every page, one programming phase each
    for (int p = 0; p < NPAGE; p++) begin
      f0 = fall_n; r0 = rise_n;
      for (int i = 0; i < PAGE; i++) begin
        if (i == PAGE - 1) c0 = cyc;
        wr(p * PAGE + i, (p * 37 + i * 11 + 5) & 255);
        exp_mem[p * PAGE + i] = 8'((p * 37 + i * 11 + 5) & 255);
      end
      wait_prog(f0, "R7");
      check("R4 whole page in one phase", rise_n - r0, 1);
      check_rng("R4 busy rise after last load", rise_cyc - c0, T_LOAD, T_LOAD + 10);
      check("R7 busy length", last_len, T_PROG + PAGE);
    end
    for (int p = 0; p < NPAGE; p++) check_page(p, "R3 sweep readback");

    // R3/R9: partial page, no erase needed in either direction
    f0 = fall_n;
    wr(2 * PAGE + 3, 8'h00); exp_mem[2 * PAGE + 3] = 8'h00;
    wr(2 * PAGE + 9, 8'hFF); exp_mem[2 * PAGE + 9] = 8'hFF;
    wait_prog(f0, "R9");
    check_page(2, "R3 partial page keeps others");
    f0 = fall_n;
    wr(2 * PAGE + 3, 8'hFF); exp_mem[2 * PAGE + 3] = 8'hFF;
    wr(2 * PAGE + 9, 8'h00); exp_mem[2 * PAGE + 9] = 8'h00;
    wait_prog(f0, "R9");
    rd(2 * PAGE + 3, v); check("R9 0x00 to 0xFF", v, 255);
    rd(2 * PAGE + 9, v); check("R9 0xFF to 0x00", v, 0);

    // R4: second load just inside the window joins the page
    f0 = fall_n; r0 = rise_n;
    wr(4 * PAGE + 0, 8'h3C); exp_mem[4 * PAGE + 0] = 8'h3C;
    idle(10);
    wr(4 * PAGE + 1, 8'hC3); exp_mem[4 * PAGE + 1] = 8'hC3;
    wait_prog(f0, "R4");
    idle(40);
    check("R4 late-window load shares phase", rise_n - r0, 1);
    check_page(4, "R4 late-window readback");

    // R2: address from strobe start, data from strobe end
    f0 = fall_n;
    wr_shift(1 * PAGE + 6, 1 * PAGE + 7, 8'h11, 8'h9A);
    exp_mem[1 * PAGE + 6] = 8'h9A;
    wait_prog(f0, "R2");
    rd(1 * PAGE + 6, v); check("R2 data at start address", v, 16'h9A);
    rd(1 * PAGE + 7, v); check("R2 later address untouched", v, int'(exp_mem[1 * PAGE + 7]));

    // R5: foreign page ignored and window not restarted
    f0 = fall_n; r0 = rise_n;
    c0 = cyc;
    wr(5 * PAGE + 1, 8'h5A); exp_mem[5 * PAGE + 1] = 8'h5A;
    wr(6 * PAGE + 1, 8'hA5);
    wr(6 * PAGE + 2, 8'h77);
    wait_prog(f0, "R5");
    check("R5 one phase only", rise_n - r0, 1);
    check_rng("R5 window anchored to locked page load", rise_cyc - c0, T_LOAD, T_LOAD + 10);
    check_page(5, "R5 locked page written");
    check_page(6, "R5 foreign page unchanged");

    // R6: glitch filter boundary
    r0 = rise_n;
    strobe(7 * PAGE + 4, 8'hE1, MIN_LOW - 1, 1'b0, 1'b0);
    idle(60);
    check("R6 short pulse starts nothing", rise_n - r0, 0);
    rd(7 * PAGE + 4, v); check("R6 short pulse leaves data", v, int'(exp_mem[7 * PAGE + 4]));
    f0 = fall_n;
    strobe(7 * PAGE + 4, 8'hE2, MIN_LOW, 1'b0, 1'b0);
    exp_mem[7 * PAGE + 4] = 8'hE2;
    wait_prog(f0, "R6");
    rd(7 * PAGE + 4, v); check("R6 MIN_LOW pulse accepted", v, 16'hE2);

    // R1: qualification of the strobe set
    r0 = rise_n;
    strobe(1 * PAGE + 0, 8'h0F, 4, 1'b1, 1'b0);
    strobe(1 * PAGE + 1, 8'hF0, 4, 1'b0, 1'b1);
    idle(60);
    check("R1 no programming from unqualified strobes", rise_n - r0, 0);
    check_page(1, "R1 data unchanged");

    // R8: strobes during busy dropped
    f0 = fall_n; r0 = rise_n;
    wr(3 * PAGE + 5, 8'h42); exp_mem[3 * PAGE + 5] = 8'h42;
    while (!busy) @(negedge clk);
    wr(3 * PAGE + 5, 8'h99);
    wr(3 * PAGE + 6, 8'h98);
    wait_prog(f0, "R8");
    idle(60);
    check("R8 no extra phase", rise_n - r0, 1);
    check_page(3, "R8 busy writes ignored");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule